// File: doc/BRIEF.md
# Bit-Plane Stripe Skip Scheduler

The scheduler walks the three coding passes over one bit-plane of a code-block and tells the context-formation logic which pass, stripe and column to work on. A bit-plane holds a parameterised number of stripes. Each stripe holds a parameterised number of columns, and each column holds four bits. The walk runs pass by pass. Within a pass it runs stripe by stripe, and within a stripe it runs column by column.

For every stripe the block keeps three skip flags, one per pass. The context-formation logic updates them with per-stripe status writes:

- A stripe whose bits are all significant needs nothing in the first pass.
- A stripe whose bits are all still insignificant needs nothing in the second pass.
- A stripe whose bits were all coded in one of the first two passes needs nothing in the third pass.

A stripe with nothing to code takes a single cycle, which only moves the stripe index on. No columns are scanned for it.

A start strobe launches a plane. A column handshake paces the walk through active stripes. A one-cycle done pulse marks the end of the third pass.

Top module: `stripe_skip_sched`

## Requirements
- R1: After reset, `busy`, `col_valid`, `stripe_start` and `plane_done` are 0, and `pass_code`, `stripe_idx` and `col_idx` are 0. The skip flags reset as for a plane with no significant bits: no stripe is skipped in passes 1 and 3, and every stripe is skipped in pass 2.
- R2: When `start` is high while idle, the next cycle shows `busy`=1 with pass 1, stripe 0 and column 0. `start` has no effect while `busy` is high.
- R3: Passes run in the order pass 1, pass 2, pass 3. `pass_code` is 2'b00, 2'b01 and 2'b10 for them. Within a pass, stripes run in ascending index order from 0 to NUM_STRIPES-1. Within a stripe, columns run in ascending order from 0 to NUM_COLS-1.
- R4: A cycle with `upd_we` high writes the three skip flags of stripe `upd_stripe`. `upd_all_sig` is the pass-1 skip flag, `upd_none_sig` is the pass-2 skip flag and `upd_all_coded` is the pass-3 skip flag.
- R5: A stripe skipped in the current pass occupies exactly one cycle, with `busy`=1 and `col_valid`=0, and no column is presented for it.
- R6: In a stripe that is not skipped, `col_valid` is 1. `col_idx` advances by one on each cycle with `col_adv` high and holds while `col_adv` is low. The stripe ends when `col_adv` is high on column NUM_COLS-1.
- R7: `stripe_start` is high only in the first cycle of a stripe that is not skipped, and in that cycle `col_idx` is 0.
- R8: Each pass samples the skip flags on the clock edge that begins it. A status write made during a pass does not change which stripes that pass skips. It does apply to the passes that begin after it.
- R9: In the cycle after the last stripe of pass 3 ends, `plane_done` is 1 for exactly one cycle and `busy` is 0. A `start` in that cycle or later begins a new plane.
- R10: `pass_code` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin scheduling one bit-plane |
| col_adv | input | 1 | Current column consumed; move to the next |
| upd_we | input | 1 | Write the skip flags of one stripe |
| upd_stripe | input | SW | Stripe index of the status write |
| upd_all_sig | input | 1 | Every bit of the stripe is significant |
| upd_none_sig | input | 1 | Every bit of the stripe is insignificant |
| upd_all_coded | input | 1 | Every bit of the stripe was coded in pass 1 or pass 2 |
| busy | output | 1 | A plane is being scheduled |
| pass_code | output | 2 | Current pass: 00, 01 or 10 |
| stripe_idx | output | SW | Current stripe |
| col_idx | output | CW | Current column |
| col_valid | output | 1 | The current column is to be coded |
| stripe_start | output | 1 | First cycle of a coded stripe |
| plane_done | output | 1 | One-cycle pulse at the end of pass 3 |

## Verification
The hardest case to reach from the ports is a status write that lands in the middle of a pass. The write must be ignored by the running pass and honoured by the next one. To reach it, the bench writes to the last stripe in the third cycle of pass 1. It flips that stripe's pass-1 flag, which pass 1 must not see, and its pass-2 flag, which pass 2 must see. The bench then compares the whole schedule, cycle by cycle, against a walk built from the pre-write flags for pass 1 and the post-write flags for pass 2. The same sweep over skip-flag patterns also exercises column stalls and a `start` raised while the plane is running.

// File: rtl/stripe_skip_sched.sv
module stripe_skip_sched #(
  parameter int NUM_STRIPES = 16,
  parameter int NUM_COLS    = 64,
  localparam int SW = (NUM_STRIPES > 1) ? $clog2(NUM_STRIPES) : 1,
  localparam int CW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          col_adv,
  input  logic          upd_we,
  input  logic [SW-1:0] upd_stripe,
  input  logic          upd_all_sig,
  input  logic          upd_none_sig,
  input  logic          upd_all_coded,
  output logic          busy,
  output logic [1:0]    pass_code,
  output logic [SW-1:0] stripe_idx,
  output logic [CW-1:0] col_idx,
  output logic          col_valid,
  output logic          stripe_start,
  output logic          plane_done
);

  logic [NUM_STRIPES-1:0] skip_p1, skip_p2, skip_p3, snap;
  logic          run_q, fresh_q, done_q;
  logic [1:0]    pass_q;
  logic [SW-1:0] stripe_q;
  logic [CW-1:0] col_q;

  wire cur_skip    = snap[stripe_q];
  wire last_col    = (col_q == CW'(NUM_COLS - 1));
  wire last_stripe = (stripe_q == SW'(NUM_STRIPES - 1));
  wire last_pass   = (pass_q == 2'b10);
  wire step        = run_q & (cur_skip | (col_adv & last_col));
  wire upd_ok      = upd_we & (int'(upd_stripe) < NUM_STRIPES);

  assign busy         = run_q;
  assign pass_code    = pass_q;
  assign stripe_idx   = stripe_q;
  assign col_idx      = col_q;
  assign col_valid    = run_q & ~cur_skip;
  assign stripe_start = col_valid & fresh_q;
  assign plane_done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_p1  <= '0;
      skip_p2  <= '1;
      skip_p3  <= '0;
      snap     <= '0;
      run_q    <= 1'b0;
      fresh_q  <= 1'b0;
      done_q   <= 1'b0;
      pass_q   <= 2'b00;
      stripe_q <= '0;
      col_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (upd_ok) begin
        skip_p1[upd_stripe] <= upd_all_sig;
        skip_p2[upd_stripe] <= upd_none_sig;
        skip_p3[upd_stripe] <= upd_all_coded;
      end
      if (!run_q) begin
        if (start) begin
          run_q    <= 1'b1;
          pass_q   <= 2'b00;
          stripe_q <= '0;
          col_q    <= '0;
          snap     <= skip_p1;
          fresh_q  <= 1'b1;
        end
      end else begin
        fresh_q <= 1'b0;
        if (col_valid && col_adv && !last_col) col_q <= col_q + 1'b1;
        if (step) begin
          col_q   <= '0;
          fresh_q <= 1'b1;
          if (!last_stripe) begin
            stripe_q <= stripe_q + 1'b1;
          end else begin
            stripe_q <= '0;
            if (last_pass) begin
              run_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              pass_q <= pass_q + 1'b1;
              snap   <= (pass_q == 2'b00) ? skip_p2 : skip_p3;
            end
          end
        end
      end
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plane_done |=> !plane_done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    plane_done |-> !busy);

  // R10
  pass_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_code != 2'b11);

  // R7
  sstart_col0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stripe_start |-> (col_valid && col_idx == '0));

  // R6
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_adv) |=> ($stable(col_idx) && $stable(stripe_idx) && $stable(pass_code)));

  // R5
  skip_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !col_valid) |=> (!busy || stripe_idx != $past(stripe_idx) || pass_code != $past(pass_code)));

  // R6
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col_idx) < NUM_COLS);

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step) |=> (stripe_idx == $past(stripe_idx) && pass_code == $past(pass_code)));

endmodule

// File: tb/test_stripe_skip_sched.sv
module test_stripe_skip_sched;
  localparam int NS = 4;
  localparam int NC = 3;
  localparam int SW = 2;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, col_adv = 1'b0, upd_we = 1'b0;
  logic [SW-1:0] upd_stripe = '0;
  logic upd_all_sig = 1'b0, upd_none_sig = 1'b0, upd_all_coded = 1'b0;
  logic busy, col_valid, stripe_start, plane_done;
  logic [1:0] pass_code;
  logic [SW-1:0] stripe_idx;
  logic [CW-1:0] col_idx;

  int vectors = 0, miscompares = 0, cyc = 0;
  bit mw_en = 0, sg_en = 0;
  logic [SW-1:0] mw_stripe = '0;
  logic mw_a = 0, mw_b = 0, mw_c = 0;

  always #4 clk = ~clk;

  stripe_skip_sched #(.NUM_STRIPES(NS), .NUM_COLS(NC)) i_stripe_skip_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .col_adv(col_adv),
    .upd_we(upd_we), .upd_stripe(upd_stripe), .upd_all_sig(upd_all_sig),
    .upd_none_sig(upd_none_sig), .upd_all_coded(upd_all_coded),
    .busy(busy), .pass_code(pass_code), .stripe_idx(stripe_idx),
    .col_idx(col_idx), .col_valid(col_valid), .stripe_start(stripe_start),
    .plane_done(plane_done));

  // observed: {busy, col_valid, stripe_start, plane_done, pass, stripe, col}
  function automatic logic [9:0] obs();
    return {busy, col_valid, stripe_start, plane_done, pass_code, stripe_idx, col_idx};
  endfunction

  task automatic chk(input string req, input logic [9:0] exp);
    vectors++;
    if (obs() !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b (cycle %0d)", req, obs(), exp, cyc);
    end
  endtask

  task automatic tick();
    if (mw_en && cyc == 2) begin
      upd_we = 1; upd_stripe = mw_stripe;
      upd_all_sig = mw_a; upd_none_sig = mw_b; upd_all_coded = mw_c;
    end else upd_we = 0;
    start = (sg_en && cyc == 5);
    @(negedge clk);
    cyc++;
  endtask

  task automatic write_flags(input int s, input logic a, input logic b, input logic c);
    upd_we = 1; upd_stripe = SW'(s); upd_all_sig = a; upd_none_sig = b; upd_all_coded = c;
    @(negedge clk);
    upd_we = 0;
  endtask

  // walk one plane; e1..e3 are the flag sets each pass is expected to use
  task automatic run_plane(input logic [NS-1:0] e1, e2, e3, input bit stall);
    int k = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 0;
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < NS; s++) begin
        logic sk;
        sk = (p == 0) ? e1[s] : (p == 1) ? e2[s] : e3[s];
        if (sk) begin
          col_adv = (k % 2 == 0);
          k++;
          // R5 R8 R3: skipped stripe, one cycle, no column
          chk("R5", {1'b1, 1'b0, 1'b0, 1'b0, 2'(p), SW'(s), CW'(0)});
          tick();
        end else begin
          for (int c = 0; c < NC; c++) begin
            bit first, adv;
            first = (c == 0);
            do begin
              adv = stall ? (k % 3 != 1) : 1'b1;
              k++;
              col_adv = adv;
              // R6 R7 R3: column presented in order, held on stall
              chk(first ? "R7" : "R6", {1'b1, 1'b1, first, 1'b0, 2'(p), SW'(s), CW'(c)});
              first = 0;
              tick();
            end while (!adv);
          end
        end
      end
    end
    col_adv = 0; upd_we = 0; start = 0;
    // R9: done pulse
    chk("R9", {1'b0, 1'b0, 1'b0, 1'b1, 2'b10, SW'(0), CW'(0)});
    @(negedge clk);
    chk("R9", {1'b0, 1'b0, 1'b0, 1'b0, 2'b10, SW'(0), CW'(0)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", 10'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 10'b0);
    // R1 R2: reset flags -> passes 1 and 3 code all stripes, pass 2 skips all
    run_plane('0, '1, '0, 0);
    for (int k = 0; k < 256; k++) begin
      logic [NS-1:0] v1, v2, v3, e2;
      bit st, mw, sg;
      v1 = k[3:0]; v2 = k[7:4]; v3 = v1 ^ ~{v2[0], v2[1], v2[2], v2[3]};
      st = k[0]; mw = k[1]; sg = k[2] ^ k[5];
      // R4: write status flags per stripe
      for (int s = 0; s < NS; s++) write_flags(s, v1[s], v2[s], v3[s]);
      // R8: mid-pass write to last stripe flips its pass-1 and pass-2 flags
      mw_en = mw; sg_en = sg; mw_stripe = SW'(NS - 1);
      mw_a = ~v1[NS-1]; mw_b = ~v2[NS-1]; mw_c = v3[NS-1];
      e2 = mw ? (v2 ^ (NS'(1) << (NS - 1))) : v2;
      // R2: start raised while busy (sg) must be ignored
      run_plane(v1, e2, v3, st);
      mw_en = 0; sg_en = 0;
      if (k % 16 == 0) @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule